// File: doc/BRIEF.md
# Byte-Wide Tuning Register Write Port

This block is the host-side write port of a digital synthesizer. It holds two 32-bit frequency words, called slot A and slot B, and two 12-bit phase offsets, one for the sine path and one for the cosine path. A host fills these registers one byte at a time over an 8-bit data bus. A 4-bit address picks the target field, an active-low select qualifies the access, and the write takes effect when the write strobe rises. The accumulator and modulation logic downstream read the four register values directly from the outputs.

Each 12-bit phase register has two fields. The high field holds bits 11 to 4 and takes a full data byte. The low field holds bits 3 to 0 and takes the upper half of the data bus. The host may write fields in any order. A field it does not rewrite keeps its old value.

The port samples the strobe in the system clock domain. A write is accepted in the clock cycle in which the strobe is seen high after being low.

Top module: `tune_reg_port`

## Requirements
- R1: A synchronous active-high `rst` sets all four registers to zero.
- R2: A write happens only on a rising edge of `wr_stb`, seen as high at a clock edge after being low at the previous edge. Holding the strobe high does not write again, even if the data changes.
- R3: While `cs_n` is high, a strobe edge changes no register.
- R4: With `addr[3]`=0, `addr[2]` selects slot A (0) or slot B (1), and `addr[1:0]`=k writes `wdata` into bits 8k+7 down to 8k of that slot.
- R5: With `addr[3]`=1, `addr[1]` selects sine (0) or cosine (1), and `addr[2]` is ignored. `addr[0]`=1 writes `wdata` into phase bits 11 to 4, and `addr[0]`=0 writes the low field.
- R6: A low-field phase write stores `wdata[7:4]` into phase bits 3 to 0. `wdata[3:0]` is ignored.
- R7: A write changes only the addressed byte or nibble. Every other bit of all four registers keeps its value.
- R8: Fields may be written in any order, and fields that are not rewritten keep their earlier value.
- R9: The addressed field shows its new value on the outputs right after the clock edge at which the strobe is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_stb | input | 1 | Write strobe; a rising edge commits the write |
| addr | input | 4 | Field select |
| wdata | input | 8 | Write data byte |
| freq_a | output | 32 | Frequency slot A |
| freq_b | output | 32 | Frequency slot B |
| phase_sin | output | 12 | Sine phase offset |
| phase_cos | output | 12 | Cosine phase offset |

## Verification
Each result is due one clock edge after the strobe is raised. The bench drives the address, data, select and strobe at a falling clock edge, so the rising edge that follows is the edge that commits the write. The bench lowers the strobe at the next falling edge and compares all four outputs one falling edge after that. By then the write has landed and no later edge has touched the registers. In the hold-high test, the bench changes the data while the strobe stays high and then compares the outputs after two more edges, which confirms that holding the strobe causes no second write.

// File: rtl/tune_reg_pkg.sv
package tune_reg_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int FREQ_BYTES = 4;
  localparam int FREQ_W     = FREQ_BYTES * DATA_W;
  localparam int PH_W       = 12;
  localparam int NUM_FREQ   = 2;
  localparam int NUM_PH     = 2;
  localparam int BSEL_W     = $clog2(FREQ_BYTES);
endpackage

// File: rtl/tune_strobe_decode.sv
module tune_strobe_decode #(
  parameter int ADDR_W     = 4,
  parameter int FREQ_BYTES = 4,
  parameter int NUM_FREQ   = 2,
  parameter int NUM_PH     = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cs_n,
  input  logic                           wr_stb,
  input  logic [ADDR_W-1:0]              addr,
  output logic [NUM_FREQ*FREQ_BYTES-1:0] freq_we,
  output logic [NUM_PH-1:0]              ph_lo_we,
  output logic [NUM_PH-1:0]              ph_hi_we
);
  localparam int BSEL_W = $clog2(FREQ_BYTES);

  logic stb_q;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= wr_stb;
  end

  assign hit = wr_stb & ~stb_q & ~cs_n;

  always_comb begin
    freq_we  = '0;
    ph_lo_we = '0;
    ph_hi_we = '0;
    if (hit) begin
      if (!addr[3]) begin
        freq_we[int'(addr[2]) * FREQ_BYTES + int'(addr[BSEL_W-1:0])] = 1'b1;
      end else if (addr[0]) begin
        ph_hi_we[addr[1]] = 1'b1;
      end else begin
        ph_lo_we[addr[1]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tune_byte_bank.sv
module tune_byte_bank #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NBYTES-1:0]        byte_we,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NBYTES*DATA_W-1:0] q
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             q[b*DATA_W +: DATA_W] <= '0;
      else if (byte_we[b]) q[b*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/tune_phase_reg.sv
module tune_phase_reg #(
  parameter int DATA_W = 8,
  parameter int PH_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PH_W-1:0]   q
);
  localparam int LO_W = PH_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (hi_we) q[PH_W-1:LO_W] <= wdata;
      if (lo_we) q[LO_W-1:0]    <= wdata[DATA_W-1 -: LO_W];
    end
  end
endmodule

// File: rtl/tune_reg_port.sv
module tune_reg_port
  import tune_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FREQ_W-1:0] freq_a,
  output logic [FREQ_W-1:0] freq_b,
  output logic [PH_W-1:0]   phase_sin,
  output logic [PH_W-1:0]   phase_cos
);
  logic [NUM_FREQ*FREQ_BYTES-1:0] freq_we;
  logic [NUM_PH-1:0]              ph_lo_we;
  logic [NUM_PH-1:0]              ph_hi_we;
  logic [FREQ_W-1:0]              freq_q [NUM_FREQ];
  logic [PH_W-1:0]                ph_q   [NUM_PH];

  tune_strobe_decode #(
    .ADDR_W(ADDR_W), .FREQ_BYTES(FREQ_BYTES),
    .NUM_FREQ(NUM_FREQ), .NUM_PH(NUM_PH)
  ) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_stb(wr_stb), .addr(addr),
    .freq_we(freq_we), .ph_lo_we(ph_lo_we), .ph_hi_we(ph_hi_we)
  );

  for (genvar f = 0; f < NUM_FREQ; f++) begin : g_freq
    tune_byte_bank #(.DATA_W(DATA_W), .NBYTES(FREQ_BYTES)) u_bank (
      .clk(clk), .rst(rst),
      .byte_we(freq_we[f*FREQ_BYTES +: FREQ_BYTES]),
      .wdata(wdata), .q(freq_q[f])
    );
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    tune_phase_reg #(.DATA_W(DATA_W), .PH_W(PH_W)) u_ph (
      .clk(clk), .rst(rst), .lo_we(ph_lo_we[p]), .hi_we(ph_hi_we[p]),
      .wdata(wdata), .q(ph_q[p])
    );
  end

  assign freq_a    = freq_q[0];
  assign freq_b    = freq_q[1];
  assign phase_sin = ph_q[0];
  assign phase_cos = ph_q[1];
endmodule

// File: rtl/tune_reg_port_checker.sv
module tune_reg_port_checker
  import tune_reg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [FREQ_W-1:0] freq_a,
  input logic [FREQ_W-1:0] freq_b,
  input logic [PH_W-1:0]   phase_sin,
  input logic [PH_W-1:0]   phase_cos
);
  logic [2*FREQ_W+2*PH_W-1:0] all_regs;
  assign all_regs = {freq_a, freq_b, phase_sin, phase_cos};

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (all_regs == '0)); // R1

  AST_STB_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_stb && $past(wr_stb) |=> $stable(all_regs)); // R2

  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(all_regs)); // R3

  AST_FREQ_A_LSB: assert property (@(posedge clk) disable iff (rst)
    wr_stb && !$past(wr_stb) && !cs_n && addr == 4'b0000
    |=> freq_a[7:0] == $past(wdata)); // R4

  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones({freq_a != $past(freq_a), freq_b != $past(freq_b),
                         phase_sin != $past(phase_sin),
                         phase_cos != $past(phase_cos)}) <= 1); // R7

  AST_SIN_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb && !$past(wr_stb) && !cs_n && addr[3] && !addr[1] && !addr[0]
    |=> phase_sin[3:0] == $past(wdata[7:4]) && $stable(phase_sin[11:4])); // R6
endmodule

bind tune_reg_port tune_reg_port_checker u_chk (.*);

// File: tb/tune_reg_port_bench.sv
module tune_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_stb = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [31:0] freq_a, freq_b;
  logic [11:0] phase_sin, phase_cos;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tune_reg_port u_tune_reg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .freq_a(freq_a), .freq_b(freq_b),
    .phase_sin(phase_sin), .phase_cos(phase_cos)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [7:0]  d;
    logic        cs;
    logic [31:0] ea;
    logic [31:0] eb;
    logic [11:0] es;
    logic [11:0] ec;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 8'h11, 1'b0, 32'h00000011, 32'h00000000, 12'h000, 12'h000},
    '{4'h3, 8'h44, 1'b0, 32'h44000011, 32'h00000000, 12'h000, 12'h000},
    '{4'h1, 8'h22, 1'b0, 32'h44002211, 32'h00000000, 12'h000, 12'h000},
    '{4'h2, 8'h33, 1'b0, 32'h44332211, 32'h00000000, 12'h000, 12'h000},
    '{4'h6, 8'hDE, 1'b0, 32'h44332211, 32'h00DE0000, 12'h000, 12'h000},
    '{4'h4, 8'h01, 1'b0, 32'h44332211, 32'h00DE0001, 12'h000, 12'h000},
    '{4'h7, 8'hAB, 1'b1, 32'h44332211, 32'h00DE0001, 12'h000, 12'h000},
    '{4'h7, 8'hAB, 1'b0, 32'h44332211, 32'hABDE0001, 12'h000, 12'h000},
    '{4'h9, 8'h5C, 1'b0, 32'h44332211, 32'hABDE0001, 12'h5C0, 12'h000},
    '{4'h8, 8'hA7, 1'b0, 32'h44332211, 32'hABDE0001, 12'h5CA, 12'h000},
    '{4'hB, 8'hF0, 1'b0, 32'h44332211, 32'hABDE0001, 12'h5CA, 12'hF00},
    '{4'hA, 8'h3F, 1'b0, 32'h44332211, 32'hABDE0001, 12'h5CA, 12'hF03},
    '{4'hE, 8'h90, 1'b0, 32'h44332211, 32'hABDE0001, 12'h5CA, 12'hF09},
    '{4'h0, 8'hFF, 1'b1, 32'h44332211, 32'hABDE0001, 12'h5CA, 12'hF09},
    '{4'h1, 8'h77, 1'b0, 32'h44337711, 32'hABDE0001, 12'h5CA, 12'hF09}
  };

  task automatic check_all(input string req, input logic [31:0] ea, input logic [31:0] eb,
                           input logic [11:0] es, input logic [11:0] ec);
    total++;
    if (freq_a !== ea || freq_b !== eb || phase_sin !== es || phase_cos !== ec) begin
      bad++;
      $display("FAIL %s: got a=%h b=%h s=%h c=%h expected a=%h b=%h s=%h c=%h",
               req, freq_a, freq_b, phase_sin, phase_cos, ea, eb, es, ec);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    addr = a; wdata = d; cs_n = cs; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset state", 32'h0, 32'h0, 12'h0, 12'h0);

    // Vector walk: R4 R5 R6 R3 R7 R8, sampled per the R9 timing
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].a, VEC[i].d, VEC[i].cs);
      check_all($sformatf("R4/R5/R6/R3/R7/R8/R9 vec %0d", i),
                VEC[i].ea, VEC[i].eb, VEC[i].es, VEC[i].ec);
    end

    // R9: new value visible right after the first edge that sees the strobe high
    @(negedge clk);
    addr = 4'h5; wdata = 8'hC3; cs_n = 1'b0; wr_stb = 1'b1;
    @(negedge clk);
    check_all("R9 one-edge latency", 32'h44337711, 32'hABDEC301, 12'h5CA, 12'hF09);

    // R2: hold the strobe high and change the data, which must not write again
    wdata = 8'h3C;
    repeat (2) @(negedge clk);
    check_all("R2 held strobe no rewrite", 32'h44337711, 32'hABDEC301, 12'h5CA, 12'hF09);
    wr_stb = 1'b0;
    @(negedge clk);

    // R5: addr[2] ignored for a sine high-field write (addr 4'hD)
    do_write(4'hD, 8'h12, 1'b0);
    check_all("R5 addr2 ignored phase", 32'h44337711, 32'hABDEC301, 12'h12A, 12'hF09);

    // R1: reset in mid-run clears all registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset clears", 32'h0, 32'h0, 12'h0, 12'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule